// File: doc/BRIEF.md
# Sprite Table Copy Engine

This block copies a fixed number of bytes from a 256-byte-aligned page of the system address space into sprite attribute memory. It sits between the CPU bus and the rest of the system. A CPU write to the trigger register at I/O address 0xFF46 loads the upper address byte of the source page and starts the copy. Writing 0xC0, for example, selects the page that begins at 0xC000. Byte i of the page is read through a dedicated master port and written to sprite memory offset i (system address 0xFE00 + i). Offsets go up from zero, and one byte moves every `PRESCALE` clocks. With the default 4 MHz clock, a complete copy of 160 bytes takes 160 µs.

While a copy is running, the CPU bus is fenced. Only the high RAM window 0xFF80–0xFFFE, and the trigger register itself, stay reachable. Any other CPU read returns 0xFF and is not forwarded. Any other CPU write is dropped. Software therefore places a short wait loop in high RAM (around 0xFFB6), starts the copy from there, and spins until the copy ends.

The sequencer has four states:
- `ST_IDLE`: no copy is running.
- `ST_FETCH`: the source byte is requested.
- `ST_STORE`: the returned byte is written to sprite memory.
- `ST_PACE`: the sequencer waits out the remainder of the byte slot.

The transitions are:
- trigger write, from any state → `ST_FETCH`
- `ST_FETCH` → `ST_STORE`
- `ST_STORE` → `ST_PACE`. When `PRESCALE` is 2, `ST_STORE` instead goes straight to `ST_FETCH`, or to `ST_IDLE` after the last byte.
- `ST_PACE` → `ST_FETCH` at the end of the slot while bytes remain
- `ST_PACE` → `ST_IDLE` at the end of the slot of the last byte

Top module: `spr_dma`

## Requirements
- R1: After reset, busy is low, no source read and no sprite write is issued, and reading 0xFF46 returns 0x00.
- R2: A CPU write to 0xFF46 stores the data byte, and a CPU read of 0xFF46 returns the last stored byte at any time, whether or not a copy is running. Accesses to 0xFF46 are never forwarded to the memory port.
- R3: A write to 0xFF46 raises busy from the next clock. Busy then stays high for exactly BYTES×PRESCALE cycles (640 with the defaults).
- R4: In the first cycle of slot i, dma_rd is high and dma_addr equals {source byte, i}. The source memory returns the data on dma_rdata in the following cycle.
- R5: In the second cycle of slot i, oam_we is high, oam_addr equals i and oam_wdata carries the byte read for slot i. Slots follow in ascending order, one every PRESCALE cycles, for i = 0 up to BYTES−1.
- R6: While busy, a CPU read of any address outside 0xFF80–0xFFFE other than 0xFF46 returns 0xFF, and mem_rd stays low. 0xFFFF also counts as outside the window.
- R7: While busy, a CPU write to any address outside 0xFF80–0xFFFE other than 0xFF46 leaves mem_wr low.
- R8: While busy, CPU reads and writes inside 0xFF80–0xFFFE (for example 0xFFB6) are forwarded to the memory port, and read data is returned unchanged.
- R9: While idle, every CPU access other than to 0xFF46 is forwarded to the memory port, and read data is returned unchanged.
- R10: A write to 0xFF46 during a copy restarts it from slot 0 with the new source byte. Busy then lasts BYTES×PRESCALE cycles counted from that write.
- R11: The bus fence lifts in the same cycle that busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | CPU read data |
| mem_addr | output | 16 | Forwarded CPU address |
| mem_wdata | output | 8 | Forwarded CPU write data |
| mem_rd | output | 1 | Forwarded read strobe |
| mem_wr | output | 1 | Forwarded write strobe |
| mem_rdata | input | 8 | Read data for forwarded CPU reads, same cycle |
| dma_addr | output | 16 | Source read address |
| dma_rd | output | 1 | Source read strobe |
| dma_rdata | input | 8 | Source read data, valid one cycle after dma_rd |
| oam_addr | output | 8 | Sprite memory byte offset |
| oam_wdata | output | 8 | Sprite memory write data |
| oam_we | output | 1 | Sprite memory write enable |
| busy | output | 1 | Copy in progress |

## Verification
The bench builds the block with its default parameters: 160 bytes per copy, four clocks per byte and the 0xFF80–0xFFFE window. A full copy therefore ends after 640 cycles, which keeps several complete copies and a mid-copy restart well inside the run. With these values the last-slot exit from `ST_PACE` is reached, the counter's step past byte 159 is exercised, and the window edges are probed at 0xFF80-side addresses, at 0xFFFE's neighbour 0xFFFF, and at the trigger register just below the window.

// File: rtl/spr_dma_pkg.sv
`timescale 1ns/1ps
package spr_dma_pkg;

    // Sequencer states of the copy engine
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2,
        ST_PACE  = 2'd3
    } xfer_state_e;

    // Byte returned to the CPU for a fenced-off read
    localparam logic [7:0] FENCED_BYTE = 8'hFF;

endpackage

// File: rtl/spr_dma_srcreg.sv
`timescale 1ns/1ps
module spr_dma_srcreg #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hFF46
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    output logic              trig,
    output logic [DATA_W-1:0] src_page
);

    assign trig = cpu_wr && (cpu_addr == TRIG_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_page <= '0;
        end else if (trig) begin
            src_page <= cpu_wdata;
        end
    end

    // R2: the page byte follows the triggering write
    p_src_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == TRIG_ADDR) |=> (src_page == $past(cpu_wdata)));

    // R2: without a trigger write the page byte holds
    p_src_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr == TRIG_ADDR) |=> $stable(src_page));

endmodule

// File: rtl/spr_dma_fsm.sv
`timescale 1ns/1ps
module spr_dma_fsm
    import spr_dma_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned BYTES    = 160,
    parameter int unsigned PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [DATA_W-1:0] src_page,
    input  logic [DATA_W-1:0] dma_rdata,
    output logic [ADDR_W-1:0] dma_addr,
    output logic              dma_rd,
    output logic [ADDR_W-DATA_W-1:0] oam_addr,
    output logic [DATA_W-1:0] oam_wdata,
    output logic              oam_we,
    output logic              busy
);

    localparam int unsigned LOW_W = ADDR_W - DATA_W;
    localparam int unsigned PH_W  = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [LOW_W-1:0] LAST_IDX = LOW_W'(BYTES - 1);
    localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(PRESCALE - 1);
    localparam bit SHORT_SLOT = (PRESCALE == 2);

    xfer_state_e      st_q, st_d;
    logic [LOW_W-1:0] idx_q;
    logic [PH_W-1:0]  ph_q;
    logic             last_byte;
    logic             slot_end;

    assign last_byte = (idx_q == LAST_IDX);
    assign slot_end  = ((st_q == ST_STORE) && SHORT_SLOT) ||
                       ((st_q == ST_PACE) && (ph_q == LAST_PH));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (trig) begin
            st_d = ST_FETCH;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_IDLE;
                ST_FETCH: st_d = ST_STORE;
                ST_STORE: begin
                    if (SHORT_SLOT) begin
                        st_d = last_byte ? ST_IDLE : ST_FETCH;
                    end else begin
                        st_d = ST_PACE;
                    end
                end
                ST_PACE: begin
                    if (ph_q == LAST_PH) begin
                        st_d = last_byte ? ST_IDLE : ST_FETCH;
                    end
                end
            endcase
        end
    end

    // Byte index and position within the byte slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            ph_q  <= '0;
        end else if (trig) begin
            idx_q <= '0;
            ph_q  <= '0;
        end else if (slot_end) begin
            idx_q <= idx_q + 1'b1;
            ph_q  <= '0;
        end else if (st_q != ST_IDLE) begin
            ph_q  <= ph_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        dma_rd    = 1'b0;
        oam_we    = 1'b0;
        busy      = 1'b1;
        unique case (st_q)
            ST_IDLE:  busy   = 1'b0;
            ST_FETCH: dma_rd = 1'b1;
            ST_STORE: oam_we = 1'b1;
            ST_PACE:  ;
        endcase
        dma_addr  = {src_page, idx_q};
        oam_addr  = idx_q;
        oam_wdata = dma_rdata;
    end

    // R3 / R10: a trigger opens slot 0 on the next cycle
    p_start_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (busy && dma_rd && dma_addr[LOW_W-1:0] == '0));

    // R5: every sprite write follows the read of the same slot
    p_store_after_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oam_we |-> ($past(dma_rd) && $past(dma_addr[LOW_W-1:0]) == oam_addr));

    // R5: writes stay inside the copied range
    p_oam_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oam_we |-> ({1'b0, oam_addr} < (LOW_W+1)'(BYTES)));

    // R4: read and write never share a cycle, and both need busy
    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dma_rd, oam_we}) <= 1 && ((dma_rd || oam_we) -> busy));

endmodule

// File: rtl/spr_dma_gate.sv
`timescale 1ns/1ps
module spr_dma_gate
    import spr_dma_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hFF46,
    parameter logic [ADDR_W-1:0] HRAM_LO   = 16'hFF80,
    parameter logic [ADDR_W-1:0] HRAM_HI   = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [DATA_W-1:0] src_page,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic in_hram;
    logic is_reg;
    logic fenced;

    assign in_hram = (cpu_addr >= HRAM_LO) && (cpu_addr <= HRAM_HI);
    assign is_reg  = (cpu_addr == TRIG_ADDR);
    assign fenced  = busy && !in_hram;

    always_comb begin
        mem_addr  = cpu_addr;
        mem_wdata = cpu_wdata;
        mem_rd    = cpu_rd && !is_reg && !fenced;
        mem_wr    = cpu_wr && !is_reg && !fenced;
        if (is_reg) begin
            cpu_rdata = src_page;
        end else if (fenced) begin
            cpu_rdata = DATA_W'(FENCED_BYTE);
        end else begin
            cpu_rdata = mem_rdata;
        end
    end

    // R6: reads outside the window see the fence byte while busy
    p_fenced_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_rd && !is_reg && (cpu_addr < HRAM_LO || cpu_addr > HRAM_HI))
        |-> (!mem_rd && cpu_rdata == DATA_W'(FENCED_BYTE)));

    // R7: writes outside the window are dropped while busy
    p_fenced_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_wr && (cpu_addr < HRAM_LO || cpu_addr > HRAM_HI)) |-> !mem_wr);

    // R8: high RAM stays reachable
    p_hram_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr >= HRAM_LO && cpu_addr <= HRAM_HI) |-> (mem_rd && cpu_rdata == mem_rdata));

    // R11 / R9: with busy low nothing but the register is held back
    p_idle_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cpu_rd && !is_reg) |-> mem_rd);

endmodule

// File: rtl/spr_dma.sv
`timescale 1ns/1ps
module spr_dma #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned BYTES    = 160,
    parameter int unsigned PRESCALE = 4,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'hFF46,
    parameter logic [ADDR_W-1:0] HRAM_LO   = 16'hFF80,
    parameter logic [ADDR_W-1:0] HRAM_HI   = 16'hFFFE
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    input  logic                     cpu_rd,
    input  logic                     cpu_wr,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    output logic                     mem_rd,
    output logic                     mem_wr,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic [ADDR_W-1:0]        dma_addr,
    output logic                     dma_rd,
    input  logic [DATA_W-1:0]        dma_rdata,
    output logic [ADDR_W-DATA_W-1:0] oam_addr,
    output logic [DATA_W-1:0]        oam_wdata,
    output logic                     oam_we,
    output logic                     busy
);

    logic              trig;
    logic [DATA_W-1:0] src_page;

    spr_dma_srcreg #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .TRIG_ADDR (TRIG_ADDR)
    ) u_srcreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_wr    (cpu_wr),
        .trig      (trig),
        .src_page  (src_page)
    );

    spr_dma_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .BYTES    (BYTES),
        .PRESCALE (PRESCALE)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .src_page  (src_page),
        .dma_rdata (dma_rdata),
        .dma_addr  (dma_addr),
        .dma_rd    (dma_rd),
        .oam_addr  (oam_addr),
        .oam_wdata (oam_wdata),
        .oam_we    (oam_we),
        .busy      (busy)
    );

    spr_dma_gate #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .TRIG_ADDR (TRIG_ADDR),
        .HRAM_LO   (HRAM_LO),
        .HRAM_HI   (HRAM_HI)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .src_page  (src_page),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_rdata (cpu_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_rdata (mem_rdata)
    );

    // R1: nothing moves while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!dma_rd && !oam_we));

endmodule

// File: tb/spr_dma_tb_top.sv
`timescale 1ns/1ps
module spr_dma_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_rdata;
    logic [15:0] dma_addr;
    logic        dma_rd;
    logic [7:0]  dma_rdata = '0;
    logic [7:0]  oam_addr;
    logic [7:0]  oam_wdata;
    logic        oam_we;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit run_chk = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spr_dma dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_rdata(cpu_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_rdata(mem_rdata),
        .dma_addr(dma_addr), .dma_rd(dma_rd), .dma_rdata(dma_rdata),
        .oam_addr(oam_addr), .oam_wdata(oam_wdata), .oam_we(oam_we),
        .busy(busy)
    );

    function automatic logic [7:0] src_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] cpu_byte(input logic [15:0] a);
        return a[7:0] + a[15:8] + 8'h11;
    endfunction

    // Memory models
    assign mem_rdata = cpu_byte(mem_addr);
    always @(posedge clk) if (dma_rd) dma_rdata <= src_byte(dma_addr);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit      m_active = 0, m_prev = 0;
    int      m_idx = 0, m_ph = 0;
    logic [7:0] m_src = 0;

    always @(posedge clk) begin
        m_prev = m_active;
        if (!rst_n) begin
            m_active = 0; m_idx = 0; m_ph = 0; m_src = 8'h00;
        end else if (cpu_wr && cpu_addr == 16'hFF46) begin
            m_src = cpu_wdata; m_active = 1; m_idx = 0; m_ph = 0;
        end else if (m_active) begin
            m_ph++;
            if (m_ph == 4) begin
                m_ph = 0;
                m_idx++;
                if (m_idx == 160) m_active = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (run_chk) begin
            bit is_reg, hram, fenced, exp_rd, exp_we;
            string tag;
            chk(busy === m_active, "R3", busy, m_active);
            exp_rd = m_active && m_ph == 0;
            exp_we = m_active && m_ph == 1;
            chk(dma_rd === exp_rd, "R4", dma_rd, exp_rd);
            if (exp_rd) chk(dma_addr === {m_src, 8'(m_idx)}, "R4", dma_addr, {m_src, 8'(m_idx)});
            chk(oam_we === exp_we, "R5", oam_we, exp_we);
            if (exp_we) begin
                chk(oam_addr === 8'(m_idx), "R5", oam_addr, m_idx);
                chk(oam_wdata === src_byte({m_src, 8'(m_idx)}), "R5", oam_wdata,
                    src_byte({m_src, 8'(m_idx)}));
            end
            is_reg = (cpu_addr == 16'hFF46);
            hram   = (cpu_addr >= 16'hFF80) && (cpu_addr <= 16'hFFFE);
            fenced = m_active && !hram;
            if (m_prev && !m_active) tag = "R11";
            else if (is_reg) tag = "R2";
            else if (fenced) tag = cpu_wr ? "R7" : "R6";
            else if (m_active) tag = "R8";
            else tag = "R9";
            chk(mem_rd === (cpu_rd && !is_reg && !fenced), tag, mem_rd, cpu_rd && !is_reg && !fenced);
            chk(mem_wr === (cpu_wr && !is_reg && !fenced), tag, mem_wr, cpu_wr && !is_reg && !fenced);
            if (cpu_rd) begin
                logic [7:0] e;
                e = is_reg ? m_src : (fenced ? 8'hFF : cpu_byte(cpu_addr));
                chk(cpu_rdata === e, tag, cpu_rdata, e);
            end
        end
    end

    task automatic drive(input logic [15:0] a, input logic [7:0] d, input bit rd, input bit wr);
        @(posedge clk); #2;
        cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = wr;
    endtask

    task automatic start(input logic [7:0] page);
        drive(16'hFF46, page, 1'b0, 1'b1);
        drive(16'h0000, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (busy) n++;
            else break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        cpu_rd = 1'b1; cpu_addr = 16'hFF46;
        run_chk = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0, "R1", busy, 0);
        chk(cpu_rdata === 8'h00, "R1", cpu_rdata, 0);
        chk(!dma_rd && !oam_we, "R1", {dma_rd, oam_we}, 0);

        // R9: idle forwarding
        drive(16'hC000, 8'h00, 1'b1, 1'b0);
        drive(16'hD000, 8'h3E, 1'b0, 1'b1);
        drive(16'hFF90, 8'h00, 1'b1, 1'b0);
        drive(16'h8000, 8'h00, 1'b1, 1'b0);

        // R3: first copy with mixed CPU traffic across the fence
        drive(16'hFF46, 8'hC0, 1'b0, 1'b1);
        for (int i = 0; i < 700; i++) begin
            case (i % 8)
                0: drive(16'hC010, 8'h00, 1'b1, 1'b0);
                1: drive(16'h8000, 8'h77, 1'b0, 1'b1);
                2: drive(16'hFFB6, 8'h00, 1'b1, 1'b0);
                3: drive(16'hFF85, 8'h28, 1'b0, 1'b1);
                4: drive(16'hFF46, 8'h00, 1'b1, 1'b0);
                5: drive(16'hFE10, 8'h00, 1'b1, 1'b0);
                6: drive(16'hFFFF, 8'h00, 1'b1, 1'b0);
                default: drive(16'hFF7F, 8'h00, 1'b1, 1'b0);
            endcase
        end
        // R2: register read back after the copy
        drive(16'hFF46, 8'h00, 1'b1, 1'b0);
        @(negedge clk);
        chk(cpu_rdata === 8'hC0, "R2", cpu_rdata, 8'hC0);

        // R3: busy length, with a fenced read held to watch it lift (R11)
        start(8'h12);
        cpu_rd = 1'b1; cpu_addr = 16'hC123;
        count_busy(n);
        chk(n == 640, "R3", n, 640);
        chk(mem_rd === 1'b1, "R11", mem_rd, 1);

        // R10: restart mid-copy
        start(8'hC0);
        repeat (50) @(posedge clk);
        start(8'hD3);
        count_busy(n);
        chk(n == 640, "R10", n, 640);

        // R4/R5: top page
        start(8'hFF);
        count_busy(n);
        chk(n == 640, "R3", n, 640);

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule